// File: doc/BRIEF.md
# Register-Literal Integer ALU

This is a purely combinational integer datapath for a small load/store processor. Each operation takes a 6-bit operation code, a first operand read from a register, and a second operand. The second operand is either a register value or a 16-bit literal taken from the instruction word. The unit returns a result of `WIDTH` bits. It also raises an illegal flag for any code it does not implement. Register file reads, memory traffic and write-back all belong to the surrounding pipeline.

The code map has two halves. The register forms occupy 0x20 to 0x2F. Each literal form sits exactly 0x10 above its register twin, so bit 4 of the code picks the operand source and bits 3:0 pick the function. The `HAS_DIV` parameter can leave out the divider. When it does, the divide codes are treated as unimplemented.

Top module: `rl_int_alu`

## Requirements
- R1: Function codes in register form are: add 0x20, subtract 0x21, multiply 0x22, divide 0x23, equal 0x24, less-than 0x25, less-or-equal 0x26, and 0x28, or 0x29, xor 0x2A, xnor 0x2B, shift-left 0x2C, logical shift-right 0x2D, arithmetic shift-right 0x2E. Add and subtract wrap modulo 2^WIDTH.
- R2: Code plus 0x10 (bit 4 set) performs the same function with the second operand taken from `lit`, sign-extended from bit 15 to WIDTH bits. `opb_reg` is then ignored.
- R3: And, or and xor are bitwise. Xnor returns the bitwise complement of the xor of both operands.
- R4: The equal, less-than and less-or-equal codes return exactly 1 when true and 0 when false. Ordering is signed two's complement.
- R5: The shift amount is the low 5 bits of the second operand. Shift-left and logical shift-right fill with zeros, and arithmetic shift-right fills with the sign bit.
- R6: Multiply returns the low WIDTH bits of the product.
- R7: Divide is signed and truncates toward zero. A zero divisor returns all ones. The most negative value divided by -1 returns the most negative value.
- R8: Codes below 0x20, and 0x27, 0x2F, 0x37 and 0x3F, set `illegal` to 1 and `result` to 0. All other codes in 0x20 to 0x3F give `illegal` 0.
- R9: With HAS_DIV = 0, codes 0x23 and 0x33 are illegal (flag 1, result 0). All other codes behave as with the divider present.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_code | input | 6 | Operation code; bit 4 selects the literal operand |
| opa | input | WIDTH | First operand (register value) |
| opb_reg | input | WIDTH | Second operand for register forms |
| lit | input | 16 | Signed literal used by literal forms |
| result | output | WIDTH | Operation result, 0 when illegal |
| illegal | output | 1 | High for an unimplemented code |

## Verification
The hardest cases to reach are the divide corners, meaning a zero divisor and the most negative value divided by -1, together with literal forms whose literal has bit 15 set. Random operands almost never produce any of these. The stimulus therefore drives each of them directly. It also sweeps every one of the 64 codes against six operand patterns chosen to include those edge values. A second instance built without the divider receives the same stimulus, so the illegal-divide behaviour is compared side by side.

// File: rtl/rl_alu_pkg.sv
// Shared function codes and helpers for the register-literal ALU.
package rl_alu_pkg;
    localparam int LIT_W = 16;
    localparam int OPC_W = 6;
    localparam int FN_W  = 4;
    localparam int LIT_SEL_BIT = 4;

    localparam logic [FN_W-1:0] FN_ADD  = 4'h0;
    localparam logic [FN_W-1:0] FN_SUB  = 4'h1;
    localparam logic [FN_W-1:0] FN_MUL  = 4'h2;
    localparam logic [FN_W-1:0] FN_DIV  = 4'h3;
    localparam logic [FN_W-1:0] FN_CEQ  = 4'h4;
    localparam logic [FN_W-1:0] FN_CLT  = 4'h5;
    localparam logic [FN_W-1:0] FN_CLE  = 4'h6;
    localparam logic [FN_W-1:0] FN_HOLE = 4'h7;
    localparam logic [FN_W-1:0] FN_AND  = 4'h8;
    localparam logic [FN_W-1:0] FN_OR   = 4'h9;
    localparam logic [FN_W-1:0] FN_XOR  = 4'hA;
    localparam logic [FN_W-1:0] FN_XNOR = 4'hB;
    localparam logic [FN_W-1:0] FN_SHL  = 4'hC;
    localparam logic [FN_W-1:0] FN_SHR  = 4'hD;
    localparam logic [FN_W-1:0] FN_SRA  = 4'hE;
    localparam logic [FN_W-1:0] FN_TOP  = 4'hF;

    typedef enum logic [1:0] {
        UNIT_ARITH  = 2'd0,
        UNIT_MULDIV = 2'd1,
        UNIT_BITOPS = 2'd2
    } unit_e;
endpackage

// File: rtl/rl_alu_decode.sv
// Operation decoder: splits the code into function and operand source and
// flags codes that are not implemented. Assumes the code map described in
// the brief; HAS_DIV=0 treats the divide function as unimplemented.
module rl_alu_decode
    import rl_alu_pkg::*;
#(
    parameter bit HAS_DIV = 1'b1
) (
    input  logic [OPC_W-1:0] op_code,
    output logic [FN_W-1:0]  fn,
    output logic             use_lit,
    output logic             legal,
    output unit_e            unit
);
    logic in_window;
    logic hole;
    logic div_off;

    // Decode the code fields and legality.
    always_comb begin
        fn        = op_code[FN_W-1:0];
        use_lit   = op_code[LIT_SEL_BIT];
        in_window = op_code[OPC_W-1];
        hole      = (fn == FN_HOLE) || (fn == FN_TOP);
        div_off   = (!HAS_DIV) && (fn == FN_DIV);
        legal     = in_window && !hole && !div_off;
    end

    // Steer the function to its execution unit.
    always_comb begin
        if (fn[FN_W-1]) begin
            unit = UNIT_BITOPS;
        end else if (fn == FN_MUL || fn == FN_DIV) begin
            unit = UNIT_MULDIV;
        end else begin
            unit = UNIT_ARITH;
        end
    end
endmodule

// File: rtl/rl_alu_arith.sv
// Add, subtract and signed compare. Shares one widened subtractor between
// subtract and the three compares; compares return 1 or 0.
module rl_alu_arith
    import rl_alu_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    input  logic [FN_W-1:0]  fn,
    output logic [WIDTH-1:0] res
);
    logic [WIDTH:0]   diff_ext;
    logic [WIDTH-1:0] sum;
    logic             is_eq;
    logic             is_lt;

    // Widened difference gives the signed order without overflow.
    always_comb begin
        diff_ext = {a[WIDTH-1], a} - {b[WIDTH-1], b};
        sum      = a + b;
        is_eq    = (diff_ext[WIDTH-1:0] == '0);
        is_lt    = diff_ext[WIDTH];
    end

    // Select the arithmetic or compare outcome.
    always_comb begin
        res = '0;
        case (fn)
            FN_ADD: res = sum;
            FN_SUB: res = diff_ext[WIDTH-1:0];
            FN_CEQ: res = {{(WIDTH-1){1'b0}}, is_eq};
            FN_CLT: res = {{(WIDTH-1){1'b0}}, is_lt};
            FN_CLE: res = {{(WIDTH-1){1'b0}}, is_lt | is_eq};
            default: res = '0;
        endcase
    end
endmodule

// File: rtl/rl_alu_bitops.sv
// Bitwise logic and the three shifts. The shift amount is the low
// log2(WIDTH) bits of the second operand.
module rl_alu_bitops
    import rl_alu_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    input  logic [FN_W-1:0]  fn,
    output logic [WIDTH-1:0] res
);
    localparam int SH_W = $clog2(WIDTH);

    logic [SH_W-1:0] shamt;

    // Pick the function; shifts use only the low amount bits.
    always_comb begin
        shamt = b[SH_W-1:0];
        res   = '0;
        case (fn)
            FN_AND:  res = a & b;
            FN_OR:   res = a | b;
            FN_XOR:  res = a ^ b;
            FN_XNOR: res = ~(a ^ b);
            FN_SHL:  res = a << shamt;
            FN_SHR:  res = a >> shamt;
            FN_SRA:  res = $unsigned($signed(a) >>> shamt);
            default: res = '0;
        endcase
    end
endmodule

// File: rtl/rl_alu_muldiv.sv
// Multiplier (low half of product) and an optional signed divider.
// Divider corner cases are resolved explicitly, without a trap.
module rl_alu_muldiv
    import rl_alu_pkg::*;
#(
    parameter int WIDTH   = 32,
    parameter bit HAS_DIV = 1'b1
) (
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    input  logic [FN_W-1:0]  fn,
    output logic [WIDTH-1:0] res
);
    localparam logic [WIDTH-1:0] MOST_NEG = {1'b1, {(WIDTH-1){1'b0}}};

    logic [WIDTH-1:0] prod;
    logic [WIDTH-1:0] quot;

    // Low half of the product is sign-agnostic.
    always_comb begin
        prod = a * b;
    end

    generate
        if (HAS_DIV) begin : g_div
            // Signed quotient with zero-divisor and overflow handling.
            always_comb begin
                if (b == '0) begin
                    quot = '1;
                end else if (a == MOST_NEG && b == '1) begin
                    quot = MOST_NEG;
                end else begin
                    quot = $unsigned($signed(a) / $signed(b));
                end
            end
        end else begin : g_no_div
            // Divider omitted; the decoder marks the code illegal.
            always_comb begin
                quot = '0;
            end
        end
    endgenerate

    // Choose between product and quotient.
    always_comb begin
        res = (fn == FN_DIV) ? quot : prod;
    end
endmodule

// File: rtl/rl_int_alu.sv
// Top of the register-literal ALU: decodes the code, forms the second
// operand, runs the three execution units and gates the result with the
// legality flag. Purely combinational; no clock or reset.
module rl_int_alu
    import rl_alu_pkg::*;
#(
    parameter int WIDTH   = 32,
    parameter bit HAS_DIV = 1'b1
) (
    input  logic [OPC_W-1:0] op_code,
    input  logic [WIDTH-1:0] opa,
    input  logic [WIDTH-1:0] opb_reg,
    input  logic [LIT_W-1:0] lit,
    output logic [WIDTH-1:0] result,
    output logic             illegal
);
    localparam int EXT_W = WIDTH - LIT_W;

    logic [FN_W-1:0]  fn;
    logic             use_lit;
    logic             legal;
    unit_e            unit;
    logic [WIDTH-1:0] opb;
    logic [WIDTH-1:0] res_arith;
    logic [WIDTH-1:0] res_bits;
    logic [WIDTH-1:0] res_md;

    rl_alu_decode #(.HAS_DIV(HAS_DIV)) u_dec (
        .op_code (op_code),
        .fn      (fn),
        .use_lit (use_lit),
        .legal   (legal),
        .unit    (unit)
    );

    // Second operand: register value or sign-extended literal.
    always_comb begin
        opb = use_lit ? {{EXT_W{lit[LIT_W-1]}}, lit} : opb_reg;
    end

    rl_alu_arith #(.WIDTH(WIDTH)) u_arith (
        .a(opa), .b(opb), .fn(fn), .res(res_arith)
    );

    rl_alu_bitops #(.WIDTH(WIDTH)) u_bits (
        .a(opa), .b(opb), .fn(fn), .res(res_bits)
    );

    rl_alu_muldiv #(.WIDTH(WIDTH), .HAS_DIV(HAS_DIV)) u_md (
        .a(opa), .b(opb), .fn(fn), .res(res_md)
    );

    // Merge unit outputs; an illegal code forces zero.
    always_comb begin
        illegal = !legal;
        result  = '0;
        if (legal) begin
            case (unit)
                UNIT_ARITH:  result = res_arith;
                UNIT_MULDIV: result = res_md;
                UNIT_BITOPS: result = res_bits;
                default:     result = '0;
            endcase
        end
    end
endmodule

// File: rtl/rl_int_alu_chk.sv
// Port-level checker for the ALU, attached by bind. Immediate assertions,
// since the block has no clock.
module rl_int_alu_chk #(
    parameter int WIDTH = 32
) (
    input logic [5:0]       op_code,
    input logic [WIDTH-1:0] opa,
    input logic [WIDTH-1:0] opb_reg,
    input logic [15:0]      lit,
    input logic [WIDTH-1:0] result,
    input logic             illegal
);
    // Port relations that must hold for every input value.
    always_comb begin
        if (illegal) begin
            AST_ILLEGAL_ZERO: assert (result == '0) else $error("illegal code with nonzero result"); // R8
        end
        if (!op_code[5]) begin
            AST_LOW_WINDOW: assert (illegal) else $error("code below 0x20 accepted"); // R8
        end
        if (!illegal && (op_code[3:0] == 4'h4 || op_code[3:0] == 4'h5 || op_code[3:0] == 4'h6)) begin
            AST_CMP_BOOL: assert (result[WIDTH-1:1] == '0) else $error("compare result not 0/1"); // R4
        end
        if (!illegal && op_code == 6'h23 && opb_reg == '0) begin
            AST_DIV_ZERO: assert (result == '1) else $error("divide by zero not all ones"); // R7
        end
        if (!illegal && op_code[4] && op_code[3:0] == 4'hC && lit[4:0] == 5'd0) begin
            AST_SHIFT_NONE: assert (result == opa) else $error("zero shift changed operand"); // R5
        end
    end
endmodule

bind rl_int_alu rl_int_alu_chk #(.WIDTH(WIDTH)) chk_i (
    .op_code (op_code),
    .opa     (opa),
    .opb_reg (opb_reg),
    .lit     (lit),
    .result  (result),
    .illegal (illegal)
);

// File: tb/rl_int_alu_tb_top.sv
// Scoreboard bench: the driver pushes expected items, the monitor pops and
// compares at the falling edge, after inputs have settled.
module rl_int_alu_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int W = 32;

    typedef struct {
        logic [5:0]   op;
        logic [W-1:0] res;
        logic         ill;
        logic [W-1:0] res_nd;
        logic         ill_nd;
        string        req;
        string        req_nd;
    } item_t;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [5:0]   op_code = '0;
    logic [W-1:0] opa = '0;
    logic [W-1:0] opb_reg = '0;
    logic [15:0]  lit = '0;
    logic [W-1:0] result, result_nd;
    logic         illegal, illegal_nd;
    int           n_chk = 0;
    int           n_fail = 0;
    item_t        sb[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    rl_int_alu #(.WIDTH(W), .HAS_DIV(1'b1)) dut_i (
        .op_code(op_code), .opa(opa), .opb_reg(opb_reg), .lit(lit),
        .result(result), .illegal(illegal)
    );

    rl_int_alu #(.WIDTH(W), .HAS_DIV(1'b0)) dut_nodiv_i (
        .op_code(op_code), .opa(opa), .opb_reg(opb_reg), .lit(lit),
        .result(result_nd), .illegal(illegal_nd)
    );

    // Behavioural model: returns {illegal, result}.
    function automatic logic [W:0] model(logic [5:0] op, logic [W-1:0] a,
                                         logic [W-1:0] breg, logic [15:0] l, bit hasdiv);
        logic [W-1:0] b;
        logic [3:0]   f;
        logic [W-1:0] r;
        b = op[4] ? {{(W-16){l[15]}}, l} : breg;
        f = op[3:0];
        if (!op[5] || f == 4'h7 || f == 4'hF || (!hasdiv && f == 4'h3))
            return {1'b1, {W{1'b0}}};
        case (f)
            4'h0: r = a + b;
            4'h1: r = a - b;
            4'h2: r = a * b;
            4'h3: begin
                if (b == 0) r = '1;
                else if (a == 32'h8000_0000 && b == 32'hFFFF_FFFF) r = 32'h8000_0000;
                else r = $signed(a) / $signed(b);
            end
            4'h4: r = {31'd0, a == b};
            4'h5: r = {31'd0, $signed(a) < $signed(b)};
            4'h6: r = {31'd0, $signed(a) <= $signed(b)};
            4'h8: r = a & b;
            4'h9: r = a | b;
            4'hA: r = a ^ b;
            4'hB: r = ~(a ^ b);
            4'hC: r = a << b[4:0];
            4'hD: r = a >> b[4:0];
            default: r = $signed(a) >>> b[4:0];
        endcase
        return {1'b0, r};
    endfunction

    function automatic string req_of(logic [5:0] op, bit hasdiv);
        logic [3:0] f;
        f = op[3:0];
        if (!op[5] || f == 4'h7 || f == 4'hF) return "R8";
        if (f == 4'h3) return hasdiv ? "R7" : "R9";
        if (op[4]) return "R2";
        if (f == 4'h2) return "R6";
        if (f >= 4'h4 && f <= 4'h6) return "R4";
        if (f >= 4'hC) return "R5";
        if (f >= 4'h8) return "R3";
        return "R1";
    endfunction

    // Driver with explicitly stated expected value for the main instance.
    task automatic send_exp(logic [5:0] op, logic [W-1:0] a, logic [W-1:0] b,
                            logic [15:0] l, logic [W-1:0] exp_r, logic exp_i, string req);
        item_t it;
        logic [W:0] m;
        @(posedge clk);
        #1;
        op_code = op; opa = a; opb_reg = b; lit = l;
        m = model(op, a, b, l, 1'b0);
        it.op = op; it.res = exp_r; it.ill = exp_i; it.req = req;
        it.res_nd = m[W-1:0]; it.ill_nd = m[W]; it.req_nd = req_of(op, 1'b0);
        sb.push_back(it);
    endtask

    // Driver with model-computed expectation.
    task automatic send(logic [5:0] op, logic [W-1:0] a, logic [W-1:0] b, logic [15:0] l);
        logic [W:0] m;
        m = model(op, a, b, l, 1'b1);
        send_exp(op, a, b, l, m[W-1:0], m[W], req_of(op, 1'b1));
    endtask

    task automatic chk(string req, string who, logic [5:0] op, logic [W-1:0] gr, logic gi,
                       logic [W-1:0] er, logic ei);
        n_chk++;
        if (gr !== er || gi !== ei) begin
            n_fail++;
            $display("FAIL %s %s op=%h got res=%h ill=%b exp res=%h ill=%b",
                     req, who, op, gr, gi, er, ei);
        end
    endtask

    // Monitor: compare both instances against the queued expectations.
    always @(negedge clk) begin
        if (sb.size() > 0) begin
            item_t it;
            it = sb.pop_front();
            chk(it.req, "div", it.op, result, illegal, it.res, it.ill);
            chk(it.req_nd, "nodiv", it.op, result_nd, illegal_nd, it.res_nd, it.ill_nd);
        end
    end

    function automatic logic [79:0] pattern(int i);
        case (i)
            0: return {32'd5, 32'd3, 16'h0003};
            1: return {32'hFFFF_FFF9, 32'd2, 16'hFFFE};
            2: return {32'h8000_0000, 32'hFFFF_FFFF, 16'hFFFF};
            3: return {32'h1234_5678, 32'd0, 16'h0000};
            4: return {32'h7FFF_FFFF, 32'h8000_0000, 16'h8000};
            default: return {32'hDEAD_BEEF, 32'h0000_0024, 16'h7FF1};
        endcase
    endfunction

    initial begin
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        // Idle state: code 0 is illegal with zero result (R8).
        send_exp(6'h00, 32'h0, 32'h0, 16'h0, 32'h0, 1'b1, "R8");
        send_exp(6'h20, 32'hFFFF_FFFF, 32'd1, 16'h0, 32'h0, 1'b0, "R1");
        send_exp(6'h21, 32'd3, 32'd5, 16'h0, 32'hFFFF_FFFE, 1'b0, "R1");
        send_exp(6'h30, 32'd5, 32'd99, 16'hFFFF, 32'd4, 1'b0, "R2");
        send_exp(6'h31, 32'd0, 32'd7, 16'h8000, 32'h0000_8000, 1'b0, "R2");
        send_exp(6'h38, 32'hFFFF_FFFF, 32'd0, 16'h8001, 32'hFFFF_8001, 1'b0, "R2");
        send_exp(6'h2B, 32'hF0F0_F0F0, 32'hFF00_FF00, 16'h0, 32'hF00F_F00F, 1'b0, "R3");
        send_exp(6'h25, 32'hFFFF_FFFF, 32'd1, 16'h0, 32'd1, 1'b0, "R4");
        send_exp(6'h25, 32'd1, 32'hFFFF_FFFF, 16'h0, 32'd0, 1'b0, "R4");
        send_exp(6'h26, 32'd7, 32'd7, 16'h0, 32'd1, 1'b0, "R4");
        send_exp(6'h34, 32'hFFFF_FFFF, 32'd0, 16'hFFFF, 32'd1, 1'b0, "R4");
        send_exp(6'h2E, 32'h8000_0000, 32'd4, 16'h0, 32'hF800_0000, 1'b0, "R5");
        send_exp(6'h2D, 32'h8000_0000, 32'd4, 16'h0, 32'h0800_0000, 1'b0, "R5");
        send_exp(6'h2C, 32'd1, 32'd33, 16'h0, 32'd2, 1'b0, "R5");
        send_exp(6'h3E, 32'h8000_0000, 32'd0, 16'h001F, 32'hFFFF_FFFF, 1'b0, "R5");
        send_exp(6'h22, 32'hFFFF_FFFD, 32'd5, 16'h0, 32'hFFFF_FFF1, 1'b0, "R6");
        send_exp(6'h22, 32'h0001_0000, 32'h0001_0000, 16'h0, 32'h0, 1'b0, "R6");
        send_exp(6'h23, 32'hFFFF_FFF9, 32'd2, 16'h0, 32'hFFFF_FFFD, 1'b0, "R7");
        send_exp(6'h23, 32'd7, 32'd0, 16'h0, 32'hFFFF_FFFF, 1'b0, "R7");
        send_exp(6'h23, 32'h8000_0000, 32'hFFFF_FFFF, 16'h0, 32'h8000_0000, 1'b0, "R7");
        send_exp(6'h33, 32'd100, 32'd0, 16'hFFFD, 32'hFFFF_FFDF, 1'b0, "R7");
        send_exp(6'h27, 32'd1, 32'd1, 16'h1, 32'h0, 1'b1, "R8");
        send_exp(6'h3F, 32'd1, 32'd1, 16'h1, 32'h0, 1'b1, "R8");
        send_exp(6'h1C, 32'd1, 32'd1, 16'h1, 32'h0, 1'b1, "R8");
        // Full code sweep; the no-divider instance covers R9.
        for (int op = 0; op < 64; op++) begin
            for (int p = 0; p < 6; p++) begin
                logic [79:0] v;
                v = pattern(p);
                send(op[5:0], v[79:48], v[47:16], v[15:0]);
            end
        end
        repeat (3) @(posedge clk);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule